// File: doc/BRIEF.md
# Dual-Mode Memory Map Controller

This controller sits between an 8-bit processor bus and its memories and peripherals. It turns each bus cycle into RAM, ROM and IO selects. A one-bit privilege mode chooses between two maps. In user mode the entire 64K address space is RAM, with no decoding at all. In system mode, reads are steered by the top address bit: the upper half goes to ROM and the lower half to an IO region. Every write, in either mode, is also stored into RAM. This keeps a RAM image of everything the system side stores.

The mode changes on bus events that the decoder can see. Fetching one reserved opcode enters system mode on the next cycle. A read of the interrupt and reset vector area does the same, and it is served from ROM in that very cycle. Fetching a second reserved opcode asks to return to user mode. That return is held back for a fixed number of cycles, so that a return-from-subroutine or return-from-interrupt fetched from ROM can finish before RAM takes over the map. While system mode is in effect, a slow-cycle output tells an external clock generator to stretch the cycle. An optional input maps the lowest pages to RAM for system-mode reads, so that zero page and the stack behave normally.

Top module: `mmap_ctrl`

## Requirements
- R1: While `sys_mode` is low, every read outside the vector area asserts only `ram_oe`; `rom_oe`, `io_oe`, `io_wr` and `slow` stay low, and `low_win_en` has no effect.
- R2: While `sys_mode` is high and the low window does not apply, a read with address bit 15 set asserts `rom_oe`, and a read with it clear asserts `io_oe`.
- R3: `ram_we` is high exactly when `rw_n` is low and `phi2` is high, in both modes; it never rises on a read.
- R4: A system-mode write with address bit 15 clear also asserts `io_wr`. A write with bit 15 set does not, and `io_wr` never rises in user mode.
- R5: With `low_win_en` high and `LOW_WIN_PAGES`=2, system-mode accesses to $0000–$01FF use RAM only: reads assert `ram_oe`, and writes leave `io_wr` low. $0200 decodes normally. With `low_win_en` low, $0100 decodes as IO.
- R6: At most one of `ram_oe`, `rom_oe` and `io_oe` is high in any cycle.
- R7: `slow` is high whenever ROM or IO is selected, and low for user-mode RAM accesses.
- R8: In user mode, a read of $FFFA–$FFFF asserts `rom_oe` and `slow` in the same cycle, and `sys_mode` is high from the next cycle. A read of $FFF9 stays in RAM.
- R9: In user mode, a read with `sync` high and `data_in` = 8'h22 sets `sys_mode` from the next cycle.
- R10: In system mode, a read with `sync` high and `data_in` = 8'h02 at cycle N keeps `sys_mode` high through cycle N+`SWITCH_DLY`, and clears it from cycle N+`SWITCH_DLY`+1. The same data with `sync` low has no effect.
- R11: Further 8'h02 fetches while a switch is pending do not restart the delay.
- R12: A vector read or an 8'h22 fetch during a pending switch cancels it, and `sys_mode` stays high.
- R13: Reset forces system mode and clears any pending switch. An idle read of $0000 then asserts `io_oe`, `slow` and `sys_mode`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus-cycle clock; registers update on the rising edge that ends each cycle |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| phi2 | input | 1 | Phase-2 level that qualifies the RAM write strobe |
| rw_n | input | 1 | 1 = read cycle, 0 = write cycle |
| sync | input | 1 | High during an opcode fetch |
| data_in | input | DATA_W | Data bus, examined for the reserved opcodes |
| addr | input | ADDR_W | Address bus |
| low_win_en | input | 1 | Maps the lowest pages to RAM in system mode |
| ram_oe | output | 1 | RAM read enable |
| ram_we | output | 1 | RAM write strobe |
| rom_oe | output | 1 | ROM read enable |
| io_oe | output | 1 | IO region read enable |
| io_wr | output | 1 | IO region write select |
| slow | output | 1 | Request for a stretched bus cycle |
| sys_mode | output | 1 | 1 while system mode is in effect |

## Verification
The bench builds the controller with `SWITCH_DLY` = 3, down from the default 4. This keeps each delayed exit short enough to check with a few table rows. It also makes the boundary cycle, the last system cycle followed by the first user cycle, land at a fixed row. That row tells a correct delay apart from one that is off by a cycle or that restarts on a repeated trigger. `LOW_WIN_PAGES` keeps its value of 2, which puts the window edge between $01FF and $0200 where a directed pair of reads can check it. The default opcode values 8'h22 and 8'h02 are used, so a fetch of either one can be separated from a plain data read that carries the same byte.

// File: rtl/mmap_pkg.sv
package mmap_pkg;

  typedef enum logic {
    MODE_USR = 1'b0,
    MODE_SYS = 1'b1
  } mode_e;

  typedef struct packed {
    logic ram_oe;
    logic rom_oe;
    logic io_oe;
    logic io_wr;
    logic slow;
  } sel_t;

endpackage

// File: rtl/mmap_rst_sync.sv
module mmap_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic meta_q;
  logic hold_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      meta_q <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      hold_q <= meta_q;
    end
  end

  assign srst_n = hold_q;

endmodule

// File: rtl/mmap_trig.sv
// Recognises the bus events that move the privilege mode.
module mmap_trig #(
  parameter int                ADDR_W = 16,
  parameter int                DATA_W = 8,
  parameter logic [DATA_W-1:0] SYS_OP = 8'h22,
  parameter logic [DATA_W-1:0] USR_OP = 8'h02,
  parameter logic [ADDR_W-1:0] VEC_LO = 16'hFFFA
) (
  input  logic              rw_n,
  input  logic              sync,
  input  logic [DATA_W-1:0] data_in,
  input  logic [ADDR_W-1:0] addr,
  output logic              sys_req,
  output logic              usr_req,
  output logic              vec_rd
);

  logic op_fetch;

  always_comb begin
    op_fetch = rw_n & sync;
    sys_req  = op_fetch & (data_in == SYS_OP);
    usr_req  = op_fetch & (data_in == USR_OP);
    vec_rd   = rw_n & (addr >= VEC_LO);
  end

endmodule

// File: rtl/mmap_mode.sv
// Privilege mode register with a deferred exit to user mode.
module mmap_mode
  import mmap_pkg::*;
#(
  parameter int SWITCH_DLY = 4
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  sys_req,
  input  logic  usr_req,
  input  logic  vec_rd,
  output mode_e mode_q,
  output logic  pend_q
);

  localparam int              CNT_W  = (SWITCH_DLY < 2) ? 1 : $clog2(SWITCH_DLY + 1);
  localparam logic [CNT_W-1:0] DLY_LD = CNT_W'(SWITCH_DLY);
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  mode_e            mode_d;
  logic             pend_d;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;
  logic             enter_sys;

  always_comb begin
    mode_d    = mode_q;
    pend_d    = pend_q;
    cnt_d     = cnt_q;
    enter_sys = sys_req | vec_rd;
    unique case (mode_q)
      MODE_USR: begin
        if (enter_sys) begin
          mode_d = MODE_SYS;
          pend_d = 1'b0;
        end
      end
      MODE_SYS: begin
        if (enter_sys) begin
          pend_d = 1'b0;
        end else if (pend_q) begin
          if (cnt_q == CNT_ONE) begin
            mode_d = MODE_USR;
            pend_d = 1'b0;
          end else begin
            cnt_d = cnt_q - CNT_ONE;
          end
        end else if (usr_req) begin
          pend_d = 1'b1;
          cnt_d  = DLY_LD;
        end
      end
      default: begin
        mode_d = MODE_SYS;
        pend_d = 1'b0;
      end
    endcase
    cnt_en = pend_q | usr_req;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_SYS;
      pend_q <= 1'b0;
    end else begin
      mode_q <= mode_d;
      pend_q <= pend_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/mmap_decode.sv
// Address decode for both maps; outputs depend only on the registered mode and the bus.
module mmap_decode
  import mmap_pkg::*;
#(
  parameter int ADDR_W        = 16,
  parameter int LOW_WIN_PAGES = 2
) (
  input  logic              sys,
  input  logic              vec_rd,
  input  logic              rw_n,
  input  logic              phi2,
  input  logic              low_win_en,
  input  logic [ADDR_W-1:0] addr,
  output sel_t              sel,
  output logic              ram_we
);

  logic win_hit;
  logic eff_sys;
  logic hi_half;

  generate
    if (LOW_WIN_PAGES > 0) begin : g_win
      localparam logic [ADDR_W:0] WIN_TOP = (ADDR_W + 1)'(LOW_WIN_PAGES * 256);
      assign win_hit = low_win_en & sys & ({1'b0, addr} < WIN_TOP);
    end else begin : g_nowin
      logic unused_en;
      assign unused_en = low_win_en;
      assign win_hit   = 1'b0;
    end
  endgenerate

  always_comb begin
    eff_sys    = sys | vec_rd;
    hi_half    = addr[ADDR_W-1];
    sel.ram_oe = rw_n & (~eff_sys | win_hit);
    sel.rom_oe = rw_n & eff_sys & ~win_hit & hi_half;
    sel.io_oe  = rw_n & eff_sys & ~win_hit & ~hi_half;
    sel.io_wr  = ~rw_n & sys & ~win_hit & ~hi_half;
    sel.slow   = eff_sys;
    ram_we     = ~rw_n & phi2;
  end

endmodule

// File: rtl/mmap_ctrl.sv
module mmap_ctrl
  import mmap_pkg::*;
#(
  parameter int                ADDR_W        = 16,
  parameter int                DATA_W        = 8,
  parameter int                SWITCH_DLY    = 4,
  parameter int                LOW_WIN_PAGES = 2,
  parameter logic [DATA_W-1:0] SYS_OP        = 8'h22,
  parameter logic [DATA_W-1:0] USR_OP        = 8'h02,
  parameter logic [ADDR_W-1:0] VEC_LO        = 16'hFFFA
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              phi2,
  input  logic              rw_n,
  input  logic              sync,
  input  logic [DATA_W-1:0] data_in,
  input  logic [ADDR_W-1:0] addr,
  input  logic              low_win_en,
  output logic              ram_oe,
  output logic              ram_we,
  output logic              rom_oe,
  output logic              io_oe,
  output logic              io_wr,
  output logic              slow,
  output logic              sys_mode
);

  logic  srst_n;
  logic  sys_req;
  logic  usr_req;
  logic  vec_rd;
  mode_e mode_q;
  logic  sw_pending;
  sel_t  sel;

  mmap_rst_sync u_rst (
    .clk   (clk),
    .arst_n(rst_n),
    .srst_n(srst_n)
  );

  mmap_trig #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .SYS_OP(SYS_OP),
    .USR_OP(USR_OP),
    .VEC_LO(VEC_LO)
  ) u_trig (
    .rw_n   (rw_n),
    .sync   (sync),
    .data_in(data_in),
    .addr   (addr),
    .sys_req(sys_req),
    .usr_req(usr_req),
    .vec_rd (vec_rd)
  );

  mmap_mode #(
    .SWITCH_DLY(SWITCH_DLY)
  ) u_mode (
    .clk    (clk),
    .rst_n  (srst_n),
    .sys_req(sys_req),
    .usr_req(usr_req),
    .vec_rd (vec_rd),
    .mode_q (mode_q),
    .pend_q (sw_pending)
  );

  mmap_decode #(
    .ADDR_W       (ADDR_W),
    .LOW_WIN_PAGES(LOW_WIN_PAGES)
  ) u_dec (
    .sys       (mode_q == MODE_SYS),
    .vec_rd    (vec_rd),
    .rw_n      (rw_n),
    .phi2      (phi2),
    .low_win_en(low_win_en),
    .addr      (addr),
    .sel       (sel),
    .ram_we    (ram_we)
  );

  assign ram_oe   = sel.ram_oe;
  assign rom_oe   = sel.rom_oe;
  assign io_oe    = sel.io_oe;
  assign io_wr    = sel.io_wr;
  assign slow     = sel.slow;
  assign sys_mode = (mode_q == MODE_SYS);

endmodule

// File: rtl/mmap_ctrl_chk.sv
module mmap_ctrl_chk #(
  parameter int                ADDR_W        = 16,
  parameter int                DATA_W        = 8,
  parameter int                SWITCH_DLY    = 4,
  parameter int                LOW_WIN_PAGES = 2,
  parameter logic [DATA_W-1:0] SYS_OP        = 8'h22,
  parameter logic [DATA_W-1:0] USR_OP        = 8'h02,
  parameter logic [ADDR_W-1:0] VEC_LO        = 16'hFFFA
) (
  input logic              clk,
  input logic              rst_n,
  input logic              phi2,
  input logic              rw_n,
  input logic              sync,
  input logic [DATA_W-1:0] data_in,
  input logic [ADDR_W-1:0] addr,
  input logic              low_win_en,
  input logic              ram_oe,
  input logic              ram_we,
  input logic              rom_oe,
  input logic              io_oe,
  input logic              io_wr,
  input logic              slow,
  input logic              sys_mode,
  input logic              sw_pending
);

  localparam logic [ADDR_W:0] LOW_TOP = (ADDR_W + 1)'(LOW_WIN_PAGES * 256);

  logic        low_hit;
  logic [31:0] age_q;

  assign low_hit = low_win_en && ({1'b0, addr} < LOW_TOP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      age_q <= '0;
    end else if (sw_pending) begin
      age_q <= age_q + 32'd1;
    end else begin
      age_q <= '0;
    end
  end

  // R1
  user_ram_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sys_mode && !(rw_n && addr >= VEC_LO)) |-> (!rom_oe && !io_oe && !io_wr && !slow));

  // R2
  sys_read_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sys_mode && rw_n && !low_hit) |-> (addr[ADDR_W-1] ? rom_oe : io_oe));

  // R3
  write_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> (!rw_n && phi2));

  // R5
  low_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sys_mode && low_hit) |-> (!io_oe && !io_wr && (ram_oe == rw_n)));

  // R6
  one_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ram_oe, rom_oe, io_oe}));

  // R7
  slow_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rom_oe || io_oe || io_wr) |-> slow);

  // R9
  sys_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sys_mode && rw_n && sync && data_in == SYS_OP) |=> sys_mode);

  // R10
  arm_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sw_pending) |-> $past(sys_mode && rw_n && sync && data_in == USR_OP));

  // R10
  delay_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sys_mode) |-> (age_q == SWITCH_DLY));

endmodule

bind mmap_ctrl mmap_ctrl_chk #(
  .ADDR_W       (ADDR_W),
  .DATA_W       (DATA_W),
  .SWITCH_DLY   (SWITCH_DLY),
  .LOW_WIN_PAGES(LOW_WIN_PAGES),
  .SYS_OP       (SYS_OP),
  .USR_OP       (USR_OP),
  .VEC_LO       (VEC_LO)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .phi2      (phi2),
  .rw_n      (rw_n),
  .sync      (sync),
  .data_in   (data_in),
  .addr      (addr),
  .low_win_en(low_win_en),
  .ram_oe    (ram_oe),
  .ram_we    (ram_we),
  .rom_oe    (rom_oe),
  .io_oe     (io_oe),
  .io_wr     (io_wr),
  .slow      (slow),
  .sys_mode  (sys_mode),
  .sw_pending(sw_pending)
);

// File: tb/tb_mmap_ctrl.sv
module tb_mmap_ctrl;

  logic        clk;
  logic        rst_n;
  logic        phi2;
  logic        rw_n;
  logic        sync;
  logic [7:0]  data_in;
  logic [15:0] addr;
  logic        low_win_en;
  logic        ram_oe, ram_we, rom_oe, io_oe, io_wr, slow, sys_mode;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 0;

  mmap_ctrl #(.SWITCH_DLY(3), .LOW_WIN_PAGES(2)) dut (
    .clk(clk), .rst_n(rst_n), .phi2(phi2), .rw_n(rw_n), .sync(sync),
    .data_in(data_in), .addr(addr), .low_win_en(low_win_en),
    .ram_oe(ram_oe), .ram_we(ram_we), .rom_oe(rom_oe), .io_oe(io_oe),
    .io_wr(io_wr), .slow(slow), .sys_mode(sys_mode)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // Row: {rw_n, sync, data, addr, phi2, low_win_en, expected, requirement}
  // expected = {sys_mode, slow, ram_oe, ram_we, rom_oe, io_oe, io_wr}
  localparam int NROW = 41;
  localparam logic [38:0] TBL [NROW] = '{
    {1'b1,1'b0,8'h00,16'h8000,1'b1,1'b0,7'b1100100,4'd2},   // R2 rom
    {1'b1,1'b0,8'h00,16'h1234,1'b1,1'b0,7'b1100010,4'd7},   // R7 io slow
    {1'b1,1'b0,8'h00,16'h0100,1'b1,1'b0,7'b1100010,4'd5},   // R5 window off
    {1'b1,1'b0,8'h00,16'h0100,1'b1,1'b1,7'b1110000,4'd5},   // R5 window on
    {1'b1,1'b0,8'h00,16'h0200,1'b1,1'b1,7'b1100010,4'd5},   // R5 edge
    {1'b1,1'b0,8'h00,16'h01FF,1'b1,1'b1,7'b1110000,4'd5},   // R5 last
    {1'b0,1'b0,8'h00,16'h4000,1'b1,1'b0,7'b1101001,4'd4},   // R4 io write
    {1'b0,1'b0,8'h00,16'h4000,1'b0,1'b0,7'b1100001,4'd3},   // R3 phi2 low
    {1'b0,1'b0,8'h00,16'hC000,1'b1,1'b0,7'b1101000,4'd4},   // R4 high write
    {1'b0,1'b0,8'h00,16'h0010,1'b1,1'b1,7'b1101000,4'd5},   // R5 window write
    {1'b1,1'b1,8'h02,16'hF000,1'b1,1'b0,7'b1100100,4'd10},  // R10 arm N
    {1'b1,1'b0,8'h00,16'hF001,1'b1,1'b0,7'b1100100,4'd10},  // R10 N+1
    {1'b1,1'b0,8'h00,16'h01FE,1'b1,1'b0,7'b1100010,4'd10},  // R10 N+2
    {1'b1,1'b0,8'h00,16'h01FF,1'b1,1'b0,7'b1100010,4'd10},  // R10 N+3
    {1'b1,1'b0,8'h00,16'h8000,1'b1,1'b0,7'b0010000,4'd10},  // R10 user now
    {1'b0,1'b0,8'h00,16'h1234,1'b1,1'b0,7'b0001000,4'd3},   // R3 user write
    {1'b1,1'b0,8'h00,16'h0100,1'b1,1'b1,7'b0010000,4'd1},   // R1 window ignored
    {1'b1,1'b1,8'h22,16'h0300,1'b1,1'b0,7'b0010000,4'd9},   // R9 fetch
    {1'b1,1'b0,8'h00,16'h8000,1'b1,1'b0,7'b1100100,4'd9},   // R9 system
    {1'b1,1'b1,8'h02,16'h8000,1'b1,1'b0,7'b1100100,4'd12},  // R12 arm
    {1'b1,1'b0,8'h00,16'h8001,1'b1,1'b0,7'b1100100,4'd12},
    {1'b1,1'b1,8'h22,16'h8002,1'b1,1'b0,7'b1100100,4'd12},  // R12 cancel
    {1'b1,1'b0,8'h00,16'h8003,1'b1,1'b0,7'b1100100,4'd12},
    {1'b1,1'b0,8'h00,16'h8004,1'b1,1'b0,7'b1100100,4'd12},  // R12 still sys
    {1'b1,1'b1,8'h02,16'h8005,1'b1,1'b0,7'b1100100,4'd11},  // R11 arm
    {1'b1,1'b1,8'h02,16'h8006,1'b1,1'b0,7'b1100100,4'd11},  // R11 repeat
    {1'b1,1'b0,8'h00,16'h8007,1'b1,1'b0,7'b1100100,4'd11},
    {1'b1,1'b0,8'h00,16'h8008,1'b1,1'b0,7'b1100100,4'd11},
    {1'b1,1'b0,8'h00,16'h8008,1'b1,1'b0,7'b0010000,4'd11},  // R11 user on time
    {1'b1,1'b0,8'h00,16'hFFFC,1'b1,1'b0,7'b0100100,4'd8},   // R8 vector
    {1'b1,1'b0,8'h00,16'hFFFD,1'b1,1'b0,7'b1100100,4'd8},   // R8 system
    {1'b1,1'b1,8'h02,16'h9000,1'b1,1'b0,7'b1100100,4'd12},  // R12 arm
    {1'b1,1'b0,8'h00,16'h9001,1'b1,1'b0,7'b1100100,4'd12},
    {1'b1,1'b0,8'h00,16'hFFFE,1'b1,1'b0,7'b1100100,4'd12},  // R12 vector cancel
    {1'b1,1'b0,8'h00,16'h9002,1'b1,1'b0,7'b1100100,4'd12},
    {1'b1,1'b0,8'h00,16'h9003,1'b1,1'b0,7'b1100100,4'd12},  // R12 still sys
    {1'b1,1'b0,8'h02,16'h9004,1'b1,1'b0,7'b1100100,4'd10},  // R10 no sync
    {1'b1,1'b0,8'h00,16'h9005,1'b1,1'b0,7'b1100100,4'd10},
    {1'b1,1'b0,8'h00,16'h9006,1'b1,1'b0,7'b1100100,4'd10},
    {1'b1,1'b0,8'h00,16'h9007,1'b1,1'b0,7'b1100100,4'd10},
    {1'b1,1'b0,8'h00,16'h9008,1'b1,1'b0,7'b1100100,4'd10}   // R10 ignored
  };

  function automatic logic [6:0] obs();
    return {sys_mode, slow, ram_oe, ram_we, rom_oe, io_oe, io_wr};
  endfunction

  task automatic drive(input logic r, input logic s, input logic [7:0] d,
                       input logic [15:0] a, input logic p, input logic l);
    @(negedge clk);
    rw_n = r; sync = s; data_in = d; addr = a; phi2 = p; low_win_en = l;
    #2;
  endtask

  task automatic idle();
    drive(1'b1, 1'b0, 8'h00, 16'h0000, 1'b0, 1'b0);
  endtask

  task automatic check(input string tag, input logic [6:0] exp);
    logic [6:0] got;
    got = obs();
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: outputs %b expected %b at addr %h", tag, got, exp, addr);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: run did not complete, got hang expected end");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    rw_n = 1'b1; sync = 1'b0; data_in = 8'h00; addr = 16'h0000;
    phi2 = 1'b0; low_win_en = 1'b0;
    repeat (3) idle();
    check("R13 reset state", 7'b1100010);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) idle();
    check("R13 after release", 7'b1100010);

    for (int i = 0; i < NROW; i++) begin
      logic [38:0] e;
      e = TBL[i];
      drive(e[38], e[37], e[36:29], e[28:13], e[12], e[11]);
      check($sformatf("R%0d row %0d", e[3:0], i), e[10:4]);
      n_chk++;
      if ($countones({ram_oe, rom_oe, io_oe}) > 1) begin
        n_err++;
        $display("FAIL R6 row %0d: enables %b expected at most one", i, {ram_oe, rom_oe, io_oe});
      end
    end

    // R8 vector-area boundary in user mode
    drive(1'b1, 1'b1, 8'h02, 16'hA000, 1'b1, 1'b0);
    check("R10 arm", 7'b1100100);
    for (int k = 0; k < 3; k++) begin
      drive(1'b1, 1'b0, 8'h00, 16'hA001, 1'b1, 1'b0);
    end
    check("R10 last system cycle", 7'b1100100);
    drive(1'b1, 1'b0, 8'h00, 16'hA004, 1'b1, 1'b0);
    check("R10 user entered", 7'b0010000);
    drive(1'b1, 1'b0, 8'h00, 16'hFFF9, 1'b1, 1'b0);
    check("R8 below vectors", 7'b0010000);
    drive(1'b1, 1'b0, 8'h00, 16'hFFFA, 1'b1, 1'b0);
    check("R8 first vector", 7'b0100100);
    drive(1'b1, 1'b0, 8'h00, 16'h8000, 1'b1, 1'b0);
    check("R8 system after vector", 7'b1100100);

    // R13 reset during a pending switch
    drive(1'b1, 1'b1, 8'h02, 16'hB000, 1'b1, 1'b0);
    @(negedge clk);
    rst_n = 1'b0;
    rw_n = 1'b1; sync = 1'b0; data_in = 8'h00; addr = 16'h0000;
    phi2 = 1'b0; low_win_en = 1'b0;
    #2;
    check("R13 async reset", 7'b1100010);
    idle();
    @(negedge clk);
    rst_n = 1'b1;
    for (int k = 0; k < 8; k++) begin
      idle();
      check("R13 pending cleared", 7'b1100010);
    end

    done = 1'b1;
    summary();
    $finish;
  end

endmodule